// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Bank

This block watches the instruction fetch stream and compares every fetched address against a small set of programmable code-address slots. Each slot holds a word-aligned compare address, its own enable, and a two-bit replace code. The replace code either turns the slot into a remap slot, or makes it raise a breakpoint on the lower halfword, the upper halfword, or both halfwords of the matched word. One global enable in a control register gates every slot. A write to the control register changes that enable only when the key bit of the same write is set.

Software programs the bank through a plain word-indexed register port. Index 0 is the control register and indices 1 to NumCode are the comparator slots. The control register also reports how many code and literal slots exist. On a fetch the bank gives a registered breakpoint pulse and a registered remap hit, together with the index of the lowest-numbered remap slot that matched. The remap of the instruction data itself lies outside this block.

Top module: `codeBkptBank`

## Requirements
- R1: After reset the global enable and every slot enable are 0, all slot registers read 0, and bkptHit, remapHit and remapIdx are 0.
- R2: Reading index 0 returns the global enable in bit 0, NumCode (default 6) in bits [7:4] and NumLit (default 2) in bits [11:8]. Bit 1 and all other bits read 0.
- R3: A write to index 0 loads bit 0 of the write data into the global enable only if bit 1 of the write data is 1. A write with bit 1 equal to 0 leaves the enable unchanged.
- R4: Index k (1 to NumCode) selects slot k-1. A write stores the replace code from bits [31:30], the compare address from bits [28:2] and the slot enable from bit 0. A read returns these bits in the same positions, with bits 29 and 1 read as 0. Indices above NumCode read 0, and writes to them change no slot.
- R5: A slot matches a fetch only if fetchAddr[28:2] equals its compare address, fetchAddr[31:29] is 0, its slot enable is 1 and the global enable is 1. fetchAddr[0] plays no part.
- R6: A matching slot with replace code 01 raises a breakpoint when fetchAddr[1] is 0. Code 10 raises one when fetchAddr[1] is 1, and code 11 raises one for either value. Code 00 never raises a breakpoint.
- R7: A matching slot with replace code 00 raises remapHit. remapIdx gives the lowest-numbered such slot, and it is 0 when remapHit is 0.
- R8: bkptHit, remapHit and remapIdx are registered. They reflect a fetch in the cycle after fetchValid is sampled high, and they are 0 in the cycle after fetchValid is sampled low.
- R9: Breakpoint and remap results from different slots are combined independently, so both outputs may be high for the same fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register word index (0 = control, 1..NumCode = slots) |
| regWrite | input | 1 | Write strobe for the register port |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| fetchValid | input | 1 | A fetch address is presented this cycle |
| fetchAddr | input | 32 | Fetched instruction byte address |
| bkptHit | output | 1 | Breakpoint raised for the previous cycle's fetch |
| remapHit | output | 1 | Remap slot matched the previous cycle's fetch |
| remapIdx | output | 4 | Lowest matching remap slot index |

## Verification
The breakpoint path and the remap path can both report on the same fetch when two slots hold the same compare address with different replace codes. The bench provokes this on purpose, with repeated remap slots and a disabled lower-numbered slot at the same address. It also does this by chance, drawing slot contents from a small address pool so that addresses collide often. Each fetch is judged against a bench model that works out the breakpoint bit, the remap bit and the lowest remap index separately from the programmed words. The outputs are then compared one cycle after the strobe, including the cycle in which the strobe falls.

// File: rtl/bkptPkg.sv
`timescale 1ns/1ps
package bkptPkg;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned COMP_LO = 2;
  localparam int unsigned COMP_HI = 28;
  localparam int unsigned COMP_W  = COMP_HI - COMP_LO + 1;
  localparam int unsigned KEY_BIT = 1;
  localparam int unsigned EN_BIT  = 0;

  typedef enum logic [1:0] {
    REP_REMAP = 2'b00,
    REP_LOWER = 2'b01,
    REP_UPPER = 2'b10,
    REP_BOTH  = 2'b11
  } replace_e;

  typedef struct packed {
    logic             globalEn;
    logic             slotSel;
    logic             slotWe;
    logic [IDX_W-1:0] slotIdx;
  } bkptStrobes_t;
endpackage

// File: rtl/bkptCtrl.sv
`timescale 1ns/1ps
module bkptCtrl
  import bkptPkg::*;
#(
  parameter int unsigned NumCode = 6,
  parameter int unsigned NumLit  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  regAddr,
  input  logic              regWrite,
  input  logic [1:0]        ctrlWdata,
  input  logic [DATA_W-1:0] slotRdata,
  output bkptStrobes_t      strobes,
  output logic [DATA_W-1:0] regRdata
);
  localparam logic [IDX_W-1:0] LastSlot = IDX_W'(NumCode);
  localparam logic [IDX_W-1:0] OneIdx   = IDX_W'(1);

  logic globalEn;
  logic ctrlSel;
  logic slotSel;
  logic [DATA_W-1:0] ctrlWord;

  assign ctrlSel = (regAddr == '0);
  assign slotSel = (regAddr >= OneIdx) && (regAddr <= LastSlot);

  // key-gated global enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
    end else if (regWrite && ctrlSel && ctrlWdata[KEY_BIT]) begin
      globalEn <= ctrlWdata[EN_BIT];
    end
  end

  always_comb begin
    ctrlWord         = '0;
    ctrlWord[EN_BIT] = globalEn;
    ctrlWord[7:4]    = 4'(NumCode);
    ctrlWord[11:8]   = 4'(NumLit);
  end

  always_comb begin
    strobes.globalEn = globalEn;
    strobes.slotSel  = slotSel;
    strobes.slotWe   = regWrite && slotSel;
    strobes.slotIdx  = regAddr - OneIdx;
  end

  always_comb begin
    if (ctrlSel) begin
      regRdata = ctrlWord;
    end else if (slotSel) begin
      regRdata = slotRdata;
    end else begin
      regRdata = '0;
    end
  end
endmodule

// File: rtl/bkptMatch.sv
`timescale 1ns/1ps
module bkptMatch
  import bkptPkg::*;
#(
  parameter int unsigned NumCode = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  bkptStrobes_t      strobes,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchAddr,
  output logic [DATA_W-1:0] slotRdata,
  output logic              bkptHit,
  output logic              remapHit,
  output logic [IDX_W-1:0]  remapIdx
);
  logic [1:0]        repQ  [NumCode];
  logic [COMP_W-1:0] compQ [NumCode];
  logic [NumCode-1:0] enQ;
  logic [NumCode-1:0] addrHit;
  logic [NumCode-1:0] bkptVec;
  logic [NumCode-1:0] remapVec;
  logic               regionOk;
  logic               halfSel;
  logic [IDX_W-1:0]   idxNext;
  logic               unusedBits;

  assign unusedBits = ^{fetchAddr[0], regWdata[29], regWdata[1]};
  assign regionOk   = (fetchAddr[DATA_W-1:COMP_HI+1] == '0);
  assign halfSel    = fetchAddr[1];

  for (genvar g = 0; g < NumCode; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        repQ[g]  <= REP_REMAP;
        compQ[g] <= '0;
        enQ[g]   <= 1'b0;
      end else if (strobes.slotWe && (strobes.slotIdx == IDX_W'(g))) begin
        repQ[g]  <= regWdata[31:30];
        compQ[g] <= regWdata[COMP_HI:COMP_LO];
        enQ[g]   <= regWdata[EN_BIT];
      end
    end

    assign addrHit[g]  = strobes.globalEn && enQ[g] && regionOk &&
                         (fetchAddr[COMP_HI:COMP_LO] == compQ[g]);
    // bit 0 of the code arms the lower halfword, bit 1 the upper one
    assign bkptVec[g]  = addrHit[g] && repQ[g][halfSel];
    assign remapVec[g] = addrHit[g] && (repQ[g] == REP_REMAP);
  end

  // lowest-numbered remap slot wins
  always_comb begin
    idxNext = '0;
    for (int i = NumCode - 1; i >= 0; i--) begin
      if (remapVec[i]) begin
        idxNext = IDX_W'(i);
      end
    end
  end

  always_comb begin
    slotRdata = '0;
    for (int i = 0; i < NumCode; i++) begin
      if (strobes.slotSel && (strobes.slotIdx == IDX_W'(i))) begin
        slotRdata[31:30]          = repQ[i];
        slotRdata[COMP_HI:COMP_LO] = compQ[i];
        slotRdata[EN_BIT]         = enQ[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bkptHit  <= 1'b0;
      remapHit <= 1'b0;
      remapIdx <= '0;
    end else begin
      bkptHit  <= fetchValid && (|bkptVec);
      remapHit <= fetchValid && (|remapVec);
      remapIdx <= fetchValid ? idxNext : '0;
    end
  end
endmodule

// File: rtl/codeBkptBank.sv
`timescale 1ns/1ps
module codeBkptBank
  import bkptPkg::*;
#(
  parameter int unsigned NumCode = 6,
  parameter int unsigned NumLit  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  regAddr,
  input  logic              regWrite,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchAddr,
  output logic              bkptHit,
  output logic              remapHit,
  output logic [IDX_W-1:0]  remapIdx
);
  bkptStrobes_t      strobes;
  logic [DATA_W-1:0] slotRdata;

  bkptCtrl #(.NumCode(NumCode), .NumLit(NumLit)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrite (regWrite),
    .ctrlWdata(regWdata[1:0]),
    .slotRdata(slotRdata),
    .strobes  (strobes),
    .regRdata (regRdata)
  );

  bkptMatch #(.NumCode(NumCode)) i_match (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regWdata  (regWdata),
    .fetchValid(fetchValid),
    .fetchAddr (fetchAddr),
    .slotRdata (slotRdata),
    .bkptHit   (bkptHit),
    .remapHit  (remapHit),
    .remapIdx  (remapIdx)
  );
endmodule

// File: rtl/codeBkptBankChk.sv
`timescale 1ns/1ps
module codeBkptBankChk #(
  parameter int unsigned NumCode = 6,
  parameter int unsigned NumLit  = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  regAddr,
  input logic        regWrite,
  input logic        keyBit,
  input logic [31:0] regRdata,
  input logic        fetchValid,
  input logic [2:0]  fetchTop,
  input logic        bkptHit,
  input logic        remapHit,
  input logic [3:0]  remapIdx,
  input logic        gEn
);
  // R8
  bkpt_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    bkptHit |-> $past(fetchValid));
  // R8
  remap_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    remapHit |-> $past(fetchValid));
  // R5
  high_region_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bkptHit || remapHit) |-> ($past(fetchTop) == 3'b000));
  // R5
  global_off_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bkptHit || remapHit) |-> $past(gEn));
  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    remapHit |-> (remapIdx < 4'(NumCode)));
  // R7
  idx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !remapHit |-> (remapIdx == 4'd0));
  // R3
  keyless_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && (regAddr == 4'd0) && !keyBit) |=> $stable(gEn));
  // R2
  ctrl_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 4'd0) |-> ((regRdata[7:4] == 4'(NumCode)) &&
                           (regRdata[11:8] == 4'(NumLit)) &&
                           (regRdata[31:12] == 20'd0) &&
                           (regRdata[3:1] == 3'd0)));
  // R4
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > 4'(NumCode)) |-> (regRdata == 32'd0));
endmodule

bind codeBkptBank codeBkptBankChk #(.NumCode(NumCode), .NumLit(NumLit)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrite  (regWrite),
  .keyBit    (regWdata[1]),
  .regRdata  (regRdata),
  .fetchValid(fetchValid),
  .fetchTop  (fetchAddr[31:29]),
  .bkptHit   (bkptHit),
  .remapHit  (remapHit),
  .remapIdx  (remapIdx),
  .gEn       (strobes.globalEn)
);

// File: tb/test_codeBkptBank.sv
`timescale 1ns/1ps
module test_codeBkptBank;
  localparam int NC = 6;
  localparam int NL = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrite = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        bkptHit;
  logic        remapHit;
  logic [3:0]  remapIdx;

  int checks = 0;
  int failures = 0;

  logic [1:0]  mRep [NC];
  logic [26:0] mComp[NC];
  logic        mEn  [NC];
  logic        mGen;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  codeBkptBank #(.NumCode(NC), .NumLit(NL)) i_codeBkptBank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regWdata(regWdata), .regRdata(regRdata), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .bkptHit(bkptHit), .remapHit(remapHit),
    .remapIdx(remapIdx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] slotWord(input logic [1:0] rep, input logic [26:0] comp, input logic en);
    return {rep, 1'b0, comp, 1'b0, en};
  endfunction

  function automatic logic [31:0] expRead(input logic [3:0] a);
    if (a == 4'd0) return {20'd0, 4'(NL), 4'(NC), 3'd0, mGen};
    if (a <= 4'(NC)) return slotWord(mRep[a-1], mComp[a-1], mEn[a-1]);
    return 32'd0;
  endfunction

  function automatic logic [31:0] expFetch(input logic [31:0] a);
    logic bk = 1'b0;
    logic rh = 1'b0;
    logic [3:0] idx = 4'd0;
    if (a[31:29] == 3'd0 && mGen) begin
      for (int s = 0; s < NC; s++) begin
        if (mEn[s] && mComp[s] == a[28:2]) begin
          if (mRep[s] == 2'b00 && !rh) begin
            rh = 1'b1;
            idx = 4'(s);
          end
          if (mRep[s] == 2'b11) bk = 1'b1;
          if (mRep[s] == 2'b01 && !a[1]) bk = 1'b1;
          if (mRep[s] == 2'b10 && a[1]) bk = 1'b1;
        end
      end
    end
    return {26'd0, bk, rh, idx};
  endfunction

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrite = 1'b1; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWrite = 1'b0;
    if (a == 4'd0) begin
      if (d[1]) mGen = d[0];
    end else if (a <= 4'(NC)) begin
      mRep[a-1] = d[31:30]; mComp[a-1] = d[28:2]; mEn[a-1] = d[0];
    end
  endtask

  task automatic readCheck(input logic [3:0] a, input string tag);
    @(negedge clk);
    regAddr = a; regWrite = 1'b0;
    #1 check(tag, regRdata, expRead(a));
  endtask

  task automatic fetchCheck(input logic [31:0] a, input string tag);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a;
    @(posedge clk);
    @(negedge clk);
    fetchValid = 1'b0;
    #1 check(tag, {26'd0, bkptHit, remapHit, remapIdx}, expFetch(a));
  endtask

  task automatic clearSlots();
    for (int s = 1; s <= NC; s++) writeReg(4'(s), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mGen = 1'b0;
    for (int s = 0; s < NC; s++) begin mRep[s] = 2'b00; mComp[s] = '0; mEn[s] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 check("R1 outputs in reset", {26'd0, bkptHit, remapHit, remapIdx}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R4: register readback after reset
    for (int a = 0; a < 16; a++) readCheck(4'(a), "R1 reset readback");
    fetchCheck({3'b0, 27'd0, 2'b00}, "R1 no hit after reset");

    // R3: key gating of the control write
    writeReg(4'd0, 32'h0000_0001);
    readCheck(4'd0, "R3 keyless enable write ignored");
    writeReg(4'd0, 32'hFFFF_FFFF);
    readCheck(4'd0, "R3 keyed enable write with all ones R2");
    writeReg(4'd0, 32'h0000_0000);
    readCheck(4'd0, "R3 keyless disable write ignored");
    writeReg(4'd0, 32'h0000_0002);
    readCheck(4'd0, "R3 keyed disable");
    writeReg(4'd0, 32'h0000_0003);
    readCheck(4'd0, "R3 keyed enable");

    // R4: field storage, reserved bits, unmapped indices
    for (int a = 1; a <= NC; a++) writeReg(4'(a), 32'hFFFF_FFFF);
    for (int a = NC + 1; a < 16; a++) writeReg(4'(a), 32'h0000_0000);
    for (int a = 0; a < 16; a++) readCheck(4'(a), "R4 readback all ones");
    for (int a = 1; a <= NC; a++) writeReg(4'(a), 32'h5A5A_A5A5 ^ 32'(a * 32'h0101_0104));
    for (int a = NC + 1; a < 16; a++) writeReg(4'(a), 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) readCheck(4'(a), "R4 readback pattern");
    clearSlots();

    // R5 R6 R7: per-slot sweep over code, enable and halfword
    for (int s = 0; s < NC; s++) begin
      for (int code = 0; code < 4; code++) begin
        for (int en = 0; en < 2; en++) begin
          logic [26:0] c;
          c = 27'h0040000 + 27'(s * 16 + code * 4 + en);
          writeReg(4'(s + 1), slotWord(2'(code), c, en[0]));
          for (int hw = 0; hw < 2; hw++) begin
            fetchCheck({3'b000, c, hw[0], 1'b0}, "R6 halfword select R7");
            fetchCheck({3'b000, c, hw[0], 1'b1}, "R5 byte bit ignored");
            fetchCheck({3'b000, c + 27'd1, hw[0], 1'b0}, "R5 address mismatch");
            fetchCheck({3'b001, c, hw[0], 1'b0}, "R5 high region never matches");
          end
          if (code == 3 && en == 1) begin
            writeReg(4'd0, 32'h0000_0002);
            fetchCheck({3'b000, c, 2'b00}, "R5 global enable off");
            writeReg(4'd0, 32'h0000_0003);
          end
          writeReg(4'(s + 1), 32'd0);
        end
      end
    end

    // R9 R7: remap and breakpoint together, lowest remap wins
    clearSlots();
    writeReg(4'd1, slotWord(2'b00, 27'h0000ABC, 1'b0));
    writeReg(4'd2, slotWord(2'b00, 27'h0000ABC, 1'b1));
    writeReg(4'd4, slotWord(2'b00, 27'h0000ABC, 1'b1));
    writeReg(4'd5, slotWord(2'b01, 27'h0000ABC, 1'b1));
    fetchCheck({3'b0, 27'h0000ABC, 2'b00}, "R9 bkpt and remap same fetch");
    fetchCheck({3'b0, 27'h0000ABC, 2'b10}, "R9 remap only upper half");

    // R8: back-to-back strobes and the cycle after the strobe falls
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = {3'b0, 27'h0000ABC, 2'b00};
    @(posedge clk);
    @(negedge clk);
    fetchAddr = {3'b0, 27'h0000ABC, 2'b10};
    #1 check("R8 first of two strobes", {26'd0, bkptHit, remapHit, remapIdx}, {26'd0, 1'b1, 1'b1, 4'd1});
    @(posedge clk);
    @(negedge clk);
    fetchValid = 1'b0;
    #1 check("R8 second of two strobes", {26'd0, bkptHit, remapHit, remapIdx}, {26'd0, 1'b0, 1'b1, 4'd1});
    @(posedge clk);
    @(negedge clk);
    #1 check("R8 outputs low after strobe falls", {26'd0, bkptHit, remapHit, remapIdx}, 32'd0);

    // R7 R9: pseudo-random slot contents over a colliding address pool
    for (int round = 0; round < 24; round++) begin
      for (int s = 0; s < NC; s++) begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        writeReg(4'(s + 1), slotWord(lcg[17:16], 27'h0001000 + 27'(lcg[25:24]) * 27'd2,
                                     lcg[20] | lcg[21]));
      end
      for (int k = 0; k < 4; k++) begin
        for (int hw = 0; hw < 2; hw++) begin
          fetchCheck({3'b0, 27'h0001000 + 27'(k) * 27'd2, hw[0], 1'b0}, "R7 R9 mixed slots");
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule